// File: doc/BRIEF.md
# ADC Engine Register Bank

This block is the register file of a single analog-to-digital conversion engine. Software reaches it through a simple 32-bit register bus with separate read and write strobes and an 8-bit byte offset, which covers a 256-byte window. The bank stores the engine control word and three further control words: one for interrupt enables, one for detection and one for the conversion clock. It also stores eight packed channel-result words, sixteen threshold-bound words, sixteen hysteresis words, an interrupt-source word and a trim word.

Each register group keeps only its own legal bits on a write. The control word has two write rules of its own. The ready flag (bit 8) always mirrors the enable bit (bit 0) of the value written. The auto-compensate flag (bit 5) is never stored. The packed channel and bound words are driven out as flat vectors, so that a separate threshold monitor can compare them without going through the bus. Reads are registered: the data appears one cycle after the read strobe, qualified by a valid flag.

Top module: `adc_regbank`

## Requirements
- R1: After reset, every register reads 0, except the detect control word (offset 0x08) and the clock control word (offset 0x0C), which read 0x0000000F.
- R2: A write to the control word (offset 0x00) stores bit 8 equal to bit 0 of the written data, whatever was written to bit 8.
- R3: A write to the control word always stores bit 5 as 0. All other bits are stored as written: channel enables [31:16], compensate bit 4, mode [3:1] and enable bit 0.
- R4: The interrupt control (0x04), detect control (0x08) and clock control (0x0C) words store and return all 32 written bits.
- R5: The channel words sit at offsets 0x10 to 0x2C, and word i sits at 0x10 + 4*i. A write keeps only bits [25:16] and [9:0] (mask 0x03FF03FF). Word i also appears on `chanWords[32*i+31:32*i]`.
- R6: The bound words sit at offsets 0x30 to 0x6C, and word i sits at 0x30 + 4*i. A write keeps mask 0x03FF03FF. Word i also appears on `boundWords[32*i+31:32*i]`.
- R7: The hysteresis words sit at offsets 0x70 to 0xAC. A write keeps bit 31 plus bits [25:16] and [9:0] (mask 0x83FF03FF).
- R8: The interrupt-source word (0xC0) keeps bits [15:0]. The trim word (0xC4) keeps bits [3:0].
- R9: A read of any offset that is unmapped or not a multiple of 4 returns 0. A write to such an offset changes no register.
- R10: Read data is presented on `rdData` with `rdValid` high in the cycle after `rdEn`. While `rdValid` is low, `rdData` is 0. A read and a write to the same offset in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the current offset |
| rdEn | input | 1 | Read strobe for the current offset |
| addr | input | 8 | Byte offset within the 256-byte window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | High in the cycle when rdData carries a read result |
| chanWords | output | 256 | Eight packed channel words, word i at bits 32*i+31:32*i |
| boundWords | output | 512 | Sixteen bound words, word i at bits 32*i+31:32*i |

## Verification
A read and a write can address the same register in the same cycle. In that case the registered read must capture the value held before the write, while the write still lands. The bench provokes this by raising both strobes on the interrupt control word and on a channel word. Its scoreboard expects the old value for that read. A plain read that follows must then return the new, masked value. The case is covered both for a full-width register and for a masked one.

// File: rtl/adc_regbank_pkg.sv
package adc_regbank_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int CHAN_N  = 8;
  localparam int BOUND_N = 16;
  localparam int HYST_N  = 16;
  localparam int IDX_W   = 4;
  localparam int CHAN_IW  = $clog2(CHAN_N);
  localparam int BOUND_IW = $clog2(BOUND_N);
  localparam int HYST_IW  = $clog2(HYST_N);

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IRQ    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DET    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLK    = 8'h0C;
  localparam logic [ADDR_W-1:0] BASE_CHAN  = 8'h10;
  localparam logic [ADDR_W-1:0] BASE_BOUND = 8'h30;
  localparam logic [ADDR_W-1:0] BASE_HYST  = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_SRC    = 8'hC0;
  localparam logic [ADDR_W-1:0] OFS_TRIM   = 8'hC4;

  localparam logic [ADDR_W:0] END_CHAN  = {1'b0, BASE_CHAN}  + (ADDR_W+1)'(4 * CHAN_N);
  localparam logic [ADDR_W:0] END_BOUND = {1'b0, BASE_BOUND} + (ADDR_W+1)'(4 * BOUND_N);
  localparam logic [ADDR_W:0] END_HYST  = {1'b0, BASE_HYST}  + (ADDR_W+1)'(4 * HYST_N);

  localparam logic [DATA_W-1:0] PAIR_MASK = 32'h03FF_03FF;
  localparam logic [DATA_W-1:0] HYST_MASK = 32'h83FF_03FF;
  localparam logic [DATA_W-1:0] SRC_MASK  = 32'h0000_FFFF;
  localparam logic [DATA_W-1:0] TRIM_MASK = 32'h0000_000F;
  localparam logic [DATA_W-1:0] DET_RST   = 32'h0000_000F;
  localparam logic [DATA_W-1:0] CLK_RST   = 32'h0000_000F;

  localparam int ENABLE_BIT   = 0;
  localparam int AUTOCOMP_BIT = 5;
  localparam int READY_BIT    = 8;

  typedef enum logic [3:0] {
    GRP_NONE, GRP_CTRL, GRP_IRQ, GRP_DET, GRP_CLK,
    GRP_CHAN, GRP_BOUND, GRP_HYST, GRP_SRC, GRP_TRIM
  } regGroupE;

  typedef struct packed {
    regGroupE         grp;
    logic [IDX_W-1:0] idx;
    logic             wr;
    logic             rd;
  } accessStrobeS;

endpackage

// File: rtl/adc_regbank_ctrl.sv
module adc_regbank_ctrl
  import adc_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output accessStrobeS      strobe,
  output logic              rdValid
);

  regGroupE          grp;
  logic [ADDR_W-1:0] groupOfs;
  logic [ADDR_W:0]   addrWide;

  assign addrWide = {1'b0, addr};

  always_comb begin
    grp      = GRP_NONE;
    groupOfs = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == OFS_CTRL) begin
        grp = GRP_CTRL;
      end else if (addr == OFS_IRQ) begin
        grp = GRP_IRQ;
      end else if (addr == OFS_DET) begin
        grp = GRP_DET;
      end else if (addr == OFS_CLK) begin
        grp = GRP_CLK;
      end else if (addr >= BASE_CHAN && addrWide < END_CHAN) begin
        grp      = GRP_CHAN;
        groupOfs = addr - BASE_CHAN;
      end else if (addr >= BASE_BOUND && addrWide < END_BOUND) begin
        grp      = GRP_BOUND;
        groupOfs = addr - BASE_BOUND;
      end else if (addr >= BASE_HYST && addrWide < END_HYST) begin
        grp      = GRP_HYST;
        groupOfs = addr - BASE_HYST;
      end else if (addr == OFS_SRC) begin
        grp = GRP_SRC;
      end else if (addr == OFS_TRIM) begin
        grp = GRP_TRIM;
      end
    end
  end

  always_comb begin
    strobe.grp = grp;
    strobe.idx = IDX_W'(groupOfs >> 2);
    strobe.wr  = wrEn;
    strobe.rd  = rdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdEn;
  end

  // R9
  aligned_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grp != GRP_NONE) |-> (addr[1:0] == 2'b00));

  // R10
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

endmodule

// File: rtl/adc_regbank_data.sv
module adc_regbank_data
  import adc_regbank_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  accessStrobeS              strobe,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  output logic [CHAN_N*DATA_W-1:0]  chanWords,
  output logic [BOUND_N*DATA_W-1:0] boundWords
);

  logic [DATA_W-1:0] ctrlReg, irqReg, detReg, clkReg, srcReg, trimReg;
  logic [DATA_W-1:0] chanMem  [CHAN_N];
  logic [DATA_W-1:0] boundMem [BOUND_N];
  logic [DATA_W-1:0] hystMem  [HYST_N];
  logic [DATA_W-1:0] ctrlNext;
  logic [DATA_W-1:0] readVal;
  logic              wrHit;

  assign wrHit = strobe.wr;

  always_comb begin
    ctrlNext               = wrData;
    ctrlNext[READY_BIT]    = wrData[ENABLE_BIT];
    ctrlNext[AUTOCOMP_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      irqReg  <= '0;
      detReg  <= DET_RST;
      clkReg  <= CLK_RST;
      srcReg  <= '0;
      trimReg <= '0;
    end else if (wrHit) begin
      case (strobe.grp)
        GRP_CTRL: ctrlReg <= ctrlNext;
        GRP_IRQ:  irqReg  <= wrData;
        GRP_DET:  detReg  <= wrData;
        GRP_CLK:  clkReg  <= wrData;
        GRP_SRC:  srcReg  <= wrData & SRC_MASK;
        GRP_TRIM: trimReg <= wrData & TRIM_MASK;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < CHAN_N; g++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        chanMem[g] <= '0;
      else if (wrHit && strobe.grp == GRP_CHAN && strobe.idx == IDX_W'(g))
        chanMem[g] <= wrData & PAIR_MASK;
    end
    assign chanWords[g*DATA_W +: DATA_W] = chanMem[g];
  end

  for (genvar g = 0; g < BOUND_N; g++) begin : gBound
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        boundMem[g] <= '0;
      else if (wrHit && strobe.grp == GRP_BOUND && strobe.idx == IDX_W'(g))
        boundMem[g] <= wrData & PAIR_MASK;
    end
    assign boundWords[g*DATA_W +: DATA_W] = boundMem[g];
  end

  for (genvar g = 0; g < HYST_N; g++) begin : gHyst
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        hystMem[g] <= '0;
      else if (wrHit && strobe.grp == GRP_HYST && strobe.idx == IDX_W'(g))
        hystMem[g] <= wrData & HYST_MASK;
    end
  end

  always_comb begin
    case (strobe.grp)
      GRP_CTRL:  readVal = ctrlReg;
      GRP_IRQ:   readVal = irqReg;
      GRP_DET:   readVal = detReg;
      GRP_CLK:   readVal = clkReg;
      GRP_CHAN:  readVal = chanMem[strobe.idx[CHAN_IW-1:0]];
      GRP_BOUND: readVal = boundMem[strobe.idx[BOUND_IW-1:0]];
      GRP_HYST:  readVal = hystMem[strobe.idx[HYST_IW-1:0]];
      GRP_SRC:   readVal = srcReg;
      GRP_TRIM:  readVal = trimReg;
      default:   readVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strobe.rd) rdData <= readVal;
    else                rdData <= '0;
  end

  // R2
  ready_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && strobe.grp == GRP_CTRL) |=> (ctrlReg[READY_BIT] == $past(wrData[ENABLE_BIT])));

  // R3
  autocomp_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && strobe.grp == GRP_CTRL) |=>
      (!ctrlReg[AUTOCOMP_BIT] && ctrlReg[31:16] == $past(wrData[31:16]) && ctrlReg[4:0] == $past(wrData[4:0])));

  // R7
  hyst_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && strobe.grp == GRP_HYST) |=> ((hystMem[$past(strobe.idx[HYST_IW-1:0])] & ~HYST_MASK) == '0));

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rd && strobe.grp == GRP_NONE) |=> (rdData == '0));

endmodule

// File: rtl/adc_regbank.sv
module adc_regbank
  import adc_regbank_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  output logic                      rdValid,
  output logic [CHAN_N*DATA_W-1:0]  chanWords,
  output logic [BOUND_N*DATA_W-1:0] boundWords
);

  accessStrobeS strobe;

  adc_regbank_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .strobe  (strobe),
    .rdValid (rdValid)
  );

  adc_regbank_data uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .rdData     (rdData),
    .chanWords  (chanWords),
    .boundWords (boundWords)
  );

  // R10
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

endmodule

// File: tb/adc_regbank_test.sv
module adc_regbank_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic         rdEn = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData;
  logic         rdValid;
  logic [255:0] chanWords;
  logic [511:0] boundWords;

  int checks = 0;
  int errors = 0;

  logic [31:0] expQ[$];
  logic [7:0]  addrQ[$];
  string       reqQ[$];

  adc_regbank uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .chanWords(chanWords), .boundWords(boundWords)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, input logic [31:0] exp, input string req);
    expQ.push_back(exp); addrQ.push_back(a); reqQ.push_back(req);
    rdEn = 1'b1; addr = a;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic rwReg(input logic [7:0] a, input logic [31:0] d, input logic [31:0] expOld, input string req);
    expQ.push_back(expOld); addrQ.push_back(a); reqQ.push_back(req);
    rdEn = 1'b1; wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rdValid) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: unexpected read result actual 0x%08h expected none", rdData);
        end else begin
          logic [31:0] e;
          logic [7:0]  a;
          string       r;
          e = expQ.pop_front(); a = addrQ.pop_front(); r = reqQ.pop_front();
          check($sformatf("%s @0x%02h", r, a), rdData, e);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1: reset values
    check("R10 idle rdData", rdData, 32'h0);
    rdReg(8'h00, 32'h0, "R1");
    rdReg(8'h04, 32'h0, "R1");
    rdReg(8'h08, 32'h0000_000F, "R1");
    rdReg(8'h0C, 32'h0000_000F, "R1");
    rdReg(8'h1C, 32'h0, "R1");
    rdReg(8'h50, 32'h0, "R1");
    rdReg(8'h90, 32'h0, "R1");
    rdReg(8'hC0, 32'h0, "R1");
    rdReg(8'hC4, 32'h0, "R1");
    check("R1 chanWords", chanWords[31:0], 32'h0);
    check("R1 boundWords", boundWords[511:480], 32'h0);

    // R9: unmapped and misaligned writes ignored, reads zero
    wrReg(8'hB0, 32'hFFFF_FFFF);
    wrReg(8'hC8, 32'hFFFF_FFFF);
    wrReg(8'hFC, 32'hFFFF_FFFF);
    wrReg(8'h0D, 32'hFFFF_FFFF);
    wrReg(8'h01, 32'hFFFF_FFFF);
    wrReg(8'h12, 32'hFFFF_FFFF);
    rdReg(8'hB0, 32'h0, "R9");
    rdReg(8'hC8, 32'h0, "R9");
    rdReg(8'hFC, 32'h0, "R9");
    rdReg(8'h0D, 32'h0, "R9");
    rdReg(8'h0C, 32'h0000_000F, "R9 neighbour");
    rdReg(8'h00, 32'h0, "R9 neighbour");
    rdReg(8'hAC, 32'h0, "R9 neighbour");
    rdReg(8'hC4, 32'h0, "R9 neighbour");
    rdReg(8'h10, 32'h0, "R9 neighbour");

    // R2 / R3: control write rules
    wrReg(8'h00, 32'h0001_003F);
    rdReg(8'h00, 32'h0001_011F, "R2 R3");
    wrReg(8'h00, 32'h8000_012E);
    rdReg(8'h00, 32'h8000_000E, "R2 R3");

    // R4: full-width control words
    wrReg(8'h04, 32'hDEAD_BEEF);
    wrReg(8'h08, 32'h1234_5678);
    wrReg(8'h0C, 32'hFFFF_FFFF);
    rdReg(8'h04, 32'hDEAD_BEEF, "R4");
    rdReg(8'h08, 32'h1234_5678, "R4");
    rdReg(8'h0C, 32'hFFFF_FFFF, "R4");

    // R5: channel words
    wrReg(8'h10, 32'hFFFF_FFFF);
    check("R5 chanWords[0]", chanWords[31:0], 32'h03FF_03FF);
    wrReg(8'h2C, 32'h1234_5678);
    check("R5 chanWords[7]", chanWords[255:224], 32'h0234_0278);
    rdReg(8'h2C, 32'h0234_0278, "R5");
    rdReg(8'h14, 32'h0, "R5");

    // R6: bound words
    wrReg(8'h6C, 32'hABCD_EF01);
    check("R6 boundWords[15]", boundWords[511:480], 32'h03CD_0301);
    wrReg(8'h30, 32'h7FFF_0001);
    check("R6 boundWords[0]", boundWords[31:0], 32'h03FF_0001);
    rdReg(8'h6C, 32'h03CD_0301, "R6");
    rdReg(8'h30, 32'h03FF_0001, "R6");

    // R7: hysteresis
    wrReg(8'hAC, 32'hFFFF_FFFF);
    wrReg(8'h70, 32'h7C00_FC00);
    rdReg(8'hAC, 32'h83FF_03FF, "R7");
    rdReg(8'h70, 32'h0, "R7");

    // R8: source and trim
    wrReg(8'hC0, 32'hFFFF_FFFF);
    wrReg(8'hC4, 32'hFFFF_FFFF);
    rdReg(8'hC0, 32'h0000_FFFF, "R8");
    rdReg(8'hC4, 32'h0000_000F, "R8");

    // R10: same-cycle read and write return the old value
    rwReg(8'h04, 32'h1111_2222, 32'hDEAD_BEEF, "R10 same-cycle");
    rdReg(8'h04, 32'h1111_2222, "R10 after");
    rwReg(8'h10, 32'h0000_0000, 32'h03FF_03FF, "R10 same-cycle");
    rdReg(8'h10, 32'h0, "R10 after");
    @(posedge clk); #1;
    check("R10 idle rdData", rdData, 32'h0);
    check("R10 idle rdValid", {31'h0, rdValid}, 32'h0);

    repeat (3) @(posedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: missing read results actual %0d pending expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule